// File: doc/BRIEF.md
# Push-button Volume Step Controller

This block turns three active-low push buttons (louder, softer, mute) and an active-low standby input into one requested attenuation setting shared by a stereo pair of channels. The setting is a tap index from 0 (no attenuation) up to the highest tap (most attenuation), plus a separate mute state. Button inputs are synchronized and filtered for contact bounce. A fresh command is not accepted during a lockout window that follows each executed command. A held louder or softer button steps the index automatically, first at a slow rate and later at a fast one.

All timing counts whole ticks of a prescaler, so a simulation can shrink every interval. With the default `TICK_DIV` of 50000 at 50 MHz, one tick lasts 1 ms. The defaults then give a 50 ms debounce, a 40 ms lockout, auto-repeat from 1 s at 250 ms per step, and 125 ms per step after a further 4 s. Each change of the requested setting appears on `pos_o` and `mute_o` together with a one-cycle `valid_o` strobe. The consumer applies the setting at a moment of its own choosing.

Top module: `vol_step_ctrl`

## Requirements
- R1: After reset `pos_o` equals `RESET_TAP` (default 10), `mute_o` is 0 and `valid_o` is 0.
- R2: A button low for fewer than `DEB_TICKS`-2 ticks never changes the outputs. A single button held low for `DEB_TICKS`+2 ticks or longer is executed exactly once before any auto-repeat.
- R3: An accepted louder press (`up_n`) lowers `pos_o` by one. An accepted softer press (`dn_n`) raises it by one.
- R4: The index saturates: louder at tap 0 and softer at the top tap (all ones) leave the outputs unchanged and give no strobe.
- R5: After any executed command, a press whose debounce completes within `LOCK_TICKS` ticks is discarded, even if it stays held.
- R6: When a louder or softer button is held, the first automatic step follows the accepted press after exactly `HOLD_TICKS` ticks. Further steps come every `SLOW_TICKS` ticks. Once `HOLD_TICKS`+`SLOW_SPAN_TICKS` ticks have passed since acceptance, they come every `FAST_TICKS` ticks.
- R7: An accepted mute press toggles `mute_o` and leaves `pos_o` unchanged. While muted, louder and softer presses have no effect.
- R8: Once two or more buttons are low at the same time, no command executes until all three buttons have been released.
- R9: While `sb_n` is low, the outputs show the park setting (`pos_o` all ones, `mute_o` 1). Button presses are discarded. After release, the setting held before standby returns.
- R10: `valid_o` is high for exactly one cycle, in the cycle in which `pos_o` or `mute_o` takes a new value, and in no other cycle.
- R11: With all four inputs high and stable, the outputs never change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_n | input | 1 | Louder button, active low (lowers the tap index) |
| dn_n | input | 1 | Softer button, active low (raises the tap index) |
| mute_n | input | 1 | Mute toggle button, active low |
| sb_n | input | 1 | Standby request, active low |
| pos_o | output | TAP_W | Requested tap index; 0 is no attenuation |
| mute_o | output | 1 | Requested mute state |
| valid_o | output | 1 | One-cycle strobe marking a new requested setting |

## Verification
The assertions check every cycle that an unmuted change moves the index by exactly one step, and that a mute toggle outside standby keeps the index. They also check that a long standby shows the park setting and that quiet inputs never produce a strobe. Only the bench scenarios can show the timing-dependent behaviour. This covers debounce rejection of short pulses, the lockout that discards a quickly repeated press, and the exact auto-repeat intervals with their switch from slow to fast. It also covers the sticky cancellation after a multi-button press and the restore of the pre-standby setting after release.

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl #(
  parameter int TICK_DIV        = 50000,
  parameter int DEB_TICKS       = 50,
  parameter int LOCK_TICKS      = 40,
  parameter int HOLD_TICKS      = 1000,
  parameter int SLOW_TICKS      = 250,
  parameter int SLOW_SPAN_TICKS = 4000,
  parameter int FAST_TICKS      = 125,
  parameter int TAP_W           = 5,
  parameter int RESET_TAP       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             mute_n,
  input  logic             sb_n,
  output logic [TAP_W-1:0] pos_o,
  output logic             mute_o,
  output logic             valid_o
);
  localparam int PW = $clog2(TICK_DIV + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam int LW = $clog2(LOCK_TICKS + 1);
  localparam int HW = $clog2(HOLD_TICKS + SLOW_SPAN_TICKS + 1);
  localparam int RW = $clog2(SLOW_TICKS + FAST_TICKS + 1);
  localparam logic [PW-1:0]    P_LAST  = PW'(TICK_DIV - 1);
  localparam logic [DW-1:0]    D_LAST  = DW'(DEB_TICKS - 1);
  localparam logic [LW-1:0]    L_INIT  = LW'(LOCK_TICKS);
  localparam logic [HW-1:0]    H_FIRST = HW'(HOLD_TICKS - 1);
  localparam logic [HW-1:0]    H_LIM   = HW'(HOLD_TICKS + SLOW_SPAN_TICKS);
  localparam logic [RW-1:0]    R_SLOW  = RW'(SLOW_TICKS - 1);
  localparam logic [RW-1:0]    R_FAST  = RW'(FAST_TICKS - 1);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W-1:0] TAP_RST = TAP_W'(RESET_TAP);

  logic [3:0]       s1, s2;
  logic [2:0]       btn, prev;
  logic [PW-1:0]    pcnt;
  logic [DW-1:0]    dcnt;
  logic [LW-1:0]    lcnt;
  logic [HW-1:0]    hcnt;
  logic [RW-1:0]    rcnt, per_last;
  logic [TAP_W-1:0] tap, nxt_pos;
  logic sb, tick, chg, multi, cancel, done, hold_act, rep, muted;
  logic fire_fresh, rep_fire, cmd, nxt_mute;

  assign btn      = s2[2:0];
  assign sb       = s2[3];
  assign tick     = (pcnt == P_LAST);
  assign chg      = (btn != prev);
  assign multi    = $countones(btn) > 1;
  assign per_last = (hcnt >= H_LIM) ? R_FAST : R_SLOW;

  assign fire_fresh = tick && !chg && (btn != 3'b000) && !done && (dcnt == D_LAST)
                      && !multi && !cancel && !sb && (lcnt == '0);
  assign rep_fire   = tick && !chg && hold_act && !sb
                      && (rep ? (rcnt == per_last) : (hcnt == H_FIRST));
  assign cmd        = fire_fresh || rep_fire;

  assign nxt_pos  = sb ? TAP_MAX : tap;
  assign nxt_mute = sb || muted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      pcnt <= '0;
    end else begin
      s1   <= {~sb_n, ~mute_n, ~dn_n, ~up_n};
      s2   <= s1;
      prev <= btn;
      pcnt <= tick ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      done   <= 1'b0;
      cancel <= 1'b0;
      lcnt   <= '0;
    end else begin
      if (btn == 3'b000)
        cancel <= 1'b0;
      else if (multi)
        cancel <= 1'b1;

      if (chg) begin
        dcnt <= '0;
        done <= 1'b0;
      end else if (tick && (btn != 3'b000) && !done) begin
        if (dcnt == D_LAST)
          done <= 1'b1;
        else
          dcnt <= dcnt + 1'b1;
      end

      if (cmd)
        lcnt <= L_INIT;
      else if (tick && (lcnt != '0))
        lcnt <= lcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_act <= 1'b0;
      rep      <= 1'b0;
      hcnt     <= '0;
      rcnt     <= '0;
    end else if (chg) begin
      hold_act <= 1'b0;
    end else if (fire_fresh) begin
      hold_act <= btn[0] | btn[1];
      rep      <= 1'b0;
      hcnt     <= '0;
      rcnt     <= '0;
    end else if (hold_act && tick) begin
      if (hcnt != H_LIM)
        hcnt <= hcnt + 1'b1;
      if (rep_fire) begin
        rcnt <= '0;
        rep  <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap     <= TAP_RST;
      muted   <= 1'b0;
      pos_o   <= TAP_RST;
      mute_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      if (cmd) begin
        if (btn[2])
          muted <= !muted;
        else if (!muted) begin
          if (btn[0] && (tap != '0))
            tap <= tap - 1'b1;
          else if (btn[1] && (tap != TAP_MAX))
            tap <= tap + 1'b1;
        end
      end
      pos_o   <= nxt_pos;
      mute_o  <= nxt_mute;
      valid_o <= (nxt_pos != pos_o) || (nxt_mute != mute_o);
    end
  end
endmodule

// File: rtl/vol_step_ctrl_chk.sv
module vol_step_ctrl_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             up_n,
  input logic             dn_n,
  input logic             mute_n,
  input logic             sb_n,
  input logic [TAP_W-1:0] pos_o,
  input logic             mute_o,
  input logic             valid_o
);
  localparam logic [TAP_W:0] ONE = 1;
  logic [2:0] idle_run, sbh_run, sbl_run;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_run <= '0;
      sbh_run  <= '0;
      sbl_run  <= '0;
      armed    <= 1'b0;
    end else begin
      armed    <= 1'b1;
      idle_run <= (up_n && dn_n && mute_n && sb_n) ? ((idle_run == 3'd7) ? idle_run : idle_run + 3'd1) : 3'd0;
      sbh_run  <= sb_n  ? ((sbh_run == 3'd7) ? sbh_run : sbh_run + 3'd1) : 3'd0;
      sbl_run  <= !sb_n ? ((sbl_run == 3'd7) ? sbl_run : sbl_run + 3'd1) : 3'd0;
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o && !mute_o && !$past(mute_o)) |->
      (({1'b0, pos_o} + ONE) == {1'b0, $past(pos_o)}) ||
      ({1'b0, pos_o} == ({1'b0, $past(pos_o)} + ONE))); // R3

  AST_PARK_SETTING: assert property (@(posedge clk) disable iff (!rst_n)
    (sbl_run >= 3'd6) |-> ((pos_o == '1) && mute_o)); // R9

  AST_MUTE_KEEPS_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && valid_o && (mute_o != $past(mute_o)) && (sbh_run >= 3'd6)) |->
      (pos_o == $past(pos_o))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_run >= 3'd6) |-> !valid_o); // R11
endmodule

bind vol_step_ctrl vol_step_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .mute_n(mute_n),
  .sb_n(sb_n), .pos_o(pos_o), .mute_o(mute_o), .valid_o(valid_o)
);

// File: tb/tb_vol_step_ctrl.sv
module tb_vol_step_ctrl;
  localparam int DIV  = 4;
  localparam int DEB  = 5;
  localparam int LOCK = 16;
  localparam int HOLD = 40;
  localparam int SLOW = 10;
  localparam int SPAN = 40;
  localparam int FAST = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_n = 1'b1, dn_n = 1'b1, mute_n = 1'b1, sb_n = 1'b1;
  logic [4:0] pos_o;
  logic mute_o, valid_o;

  int checks = 0, errors = 0, cyc = 0;
  int nstrobe = 0, last_t = 0;
  int gaps [0:63];
  bit finished = 1'b0;

  vol_step_ctrl #(.TICK_DIV(DIV), .DEB_TICKS(DEB), .LOCK_TICKS(LOCK), .HOLD_TICKS(HOLD),
    .SLOW_TICKS(SLOW), .SLOW_SPAN_TICKS(SPAN), .FAST_TICKS(FAST), .TAP_W(5), .RESET_TAP(10)) dut (
    .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n), .mute_n(mute_n), .sb_n(sb_n),
    .pos_o(pos_o), .mute_o(mute_o), .valid_o(valid_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (nstrobe < 64) gaps[nstrobe] = cyc - last_t;
      last_t = cyc;
      nstrobe = nstrobe + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic clr();
    @(negedge clk);
    nstrobe = 0;
    last_t = cyc;
  endtask

  task automatic drive(input logic [2:0] m);
    @(negedge clk);
    up_n = ~m[0]; dn_n = ~m[1]; mute_n = ~m[2];
  endtask

  task automatic press(input logic [2:0] m, input int n);
    drive(m);
    ticks(n);
    drive(3'b000);
    ticks(LOCK + 6);
  endtask

  task automatic t_reset();
    chk("R1 reset pos", pos_o, 10);
    chk("R1 reset mute", mute_o, 0);
    chk("R1 reset valid", valid_o, 0);
  endtask

  task automatic t_glitch();
    clr();
    press(3'b001, 2);
    chk("R2 short pulse pos", pos_o, 10);
    chk("R2 R11 short pulse strobes", nstrobe, 0);
  endtask

  task automatic t_single();
    clr();
    press(3'b001, DEB + 3);
    chk("R3 louder step", pos_o, 9);
    chk("R10 one strobe", nstrobe, 1);
    clr();
    press(3'b010, DEB + 3);
    chk("R3 softer step", pos_o, 10);
    chk("R2 R10 one strobe softer", nstrobe, 1);
    chk("R10 valid low after", valid_o, 0);
  endtask

  task automatic t_lock();
    clr();
    drive(3'b001); ticks(DEB + 3);
    drive(3'b000); ticks(2);
    drive(3'b001); ticks(DEB + 2);
    drive(3'b000); ticks(LOCK + 6);
    chk("R5 second press dropped", pos_o, 9);
    chk("R5 strobes", nstrobe, 1);
    press(3'b001, DEB + 3);
    chk("R5 accepted after lockout", pos_o, 8);
  endtask

  task automatic t_repeat_dn();
    int n;
    n = 31 - int'(pos_o);
    clr();
    drive(3'b010); ticks(200);
    drive(3'b000); ticks(LOCK + 6);
    chk("R6 R4 reached top", pos_o, 31);
    chk("R4 R6 strobe count", nstrobe, n);
    chk("R6 first auto gap", gaps[1], HOLD * DIV);
    chk("R6 slow gap", gaps[2], SLOW * DIV);
    chk("R6 last slow gap", gaps[5], SLOW * DIV);
    chk("R6 fast gap", gaps[6], FAST * DIV);
    chk("R6 final fast gap", gaps[n - 1], FAST * DIV);
    clr();
    press(3'b010, DEB + 3);
    chk("R4 softer at top pos", pos_o, 31);
    chk("R4 softer at top strobes", nstrobe, 0);
  endtask

  task automatic t_repeat_up();
    clr();
    drive(3'b001); ticks(260);
    drive(3'b000); ticks(LOCK + 6);
    chk("R6 R4 reached bottom", pos_o, 0);
    chk("R6 strobe count up", nstrobe, 31);
    chk("R6 fast gap up", gaps[30], FAST * DIV);
    clr();
    press(3'b001, DEB + 3);
    chk("R4 louder at zero pos", pos_o, 0);
    chk("R4 louder at zero strobes", nstrobe, 0);
  endtask

  task automatic t_mute();
    press(3'b010, DEB + 3);
    chk("R3 step before mute", pos_o, 1);
    clr();
    press(3'b100, DEB + 3);
    chk("R7 muted", mute_o, 1);
    chk("R7 tap kept", pos_o, 1);
    chk("R7 R10 mute strobe", nstrobe, 1);
    clr();
    press(3'b010, DEB + 3);
    chk("R7 softer ignored muted", pos_o, 1);
    chk("R7 no strobe muted", nstrobe, 0);
    press(3'b100, DEB + 3);
    chk("R7 unmuted", mute_o, 0);
    chk("R7 tap restored", pos_o, 1);
  endtask

  task automatic t_multi();
    clr();
    drive(3'b001); ticks(2);
    drive(3'b011); ticks(10);
    drive(3'b001); ticks(20);
    drive(3'b000); ticks(LOCK + 6);
    chk("R8 cancelled pos", pos_o, 1);
    chk("R8 cancelled strobes", nstrobe, 0);
    press(3'b001, DEB + 3);
    chk("R8 accepted after release", pos_o, 0);
  endtask

  task automatic t_standby();
    press(3'b010, DEB + 3);
    press(3'b010, DEB + 3);
    clr();
    @(negedge clk) sb_n = 1'b0;
    ticks(5);
    chk("R9 park pos", pos_o, 31);
    chk("R9 park mute", mute_o, 1);
    press(3'b001, DEB + 3);
    chk("R9 press ignored in standby", pos_o, 31);
    chk("R9 R10 one strobe entering", nstrobe, 1);
    @(negedge clk) sb_n = 1'b1;
    ticks(5);
    chk("R9 restored pos", pos_o, 2);
    chk("R9 restored mute", mute_o, 0);
    chk("R10 strobe leaving", nstrobe, 2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_glitch();
    t_single();
    t_lock();
    t_repeat_dn();
    t_repeat_up();
    t_mute();
    t_multi();
    t_standby();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule